// File: doc/BRIEF.md
# Pixel Two-Cell Hit Time Recorder

This block is the digital store of a single detector pixel. During a bunch train a shared timestamp counter is broadcast to every pixel. Each time the pixel's discriminator strobes a hit, the store copies the bus value into its next free cell and moves its write pointer on. There are two cells, so up to two hit times per train are kept. Any hit that finds both cells occupied is discarded, and a sticky overflow flag records that it happened.

Between trains the pixel is read out. A read request takes a snapshot of the store and presents it as one beat on a valid/ready port. The beat carries both cell values, a hit count of 0, 1 or 2, an empty flag for sparse readout, and the overflow flag. The beat holds every field steady until the consumer takes it with ready, so back-pressure of any length is safe. A clear control empties the store before the next train begins. Read and clear are honoured only while no train is running.

Top module: `pix_ts_recorder`

## Requirements
- R1: After reset, rd_valid_o is low and a read issued next returns count 0, empty high, overflow low and both cell fields 0.
- R2: A hit_i pulse while train_i is high and the store is empty writes ts_i into cell 0, which is rd_ts_o bits [13:0].
- R3: A second accepted hit in the same train writes cell 1 (rd_ts_o bits [27:14]) and leaves cell 0 unchanged.
- R4: Hits on consecutive clock cycles are each recorded, one per cycle, with no idle cycle needed between them.
- R5: A hit arriving while both cells are full changes neither cell nor the count, and it sets the overflow flag. The flag stays set until a clear.
- R6: A hit_i pulse while train_i is low has no effect on the store.
- R7: rd_req_i while train_i is low and no beat is pending raises rd_valid_o on the following cycle. The beat's rd_count_o equals the number of stored hits, rd_empty_o is high exactly when the count is 0, and any unwritten cell field reads 0.
- R8: rd_req_i while train_i is high is ignored: no beat is produced.
- R9: While rd_valid_o is high and rd_ready_i is low, all beat fields stay stable. A beat ends on the first clock edge where rd_ready_i is high. rd_req_i is ignored while a beat is pending.
- R10: clr_i while train_i is low zeroes the cells, the count and the overflow flag, and it withdraws any pending beat. On the same cycle it takes priority over rd_req_i. clr_i while train_i is high is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| train_i | input | 1 | High while a bunch train is running |
| hit_i | input | 1 | Discriminator hit strobe, one per cycle |
| ts_i | input | 14 | Shared timestamp bus |
| clr_i | input | 1 | Empty the store (between trains only) |
| rd_req_i | input | 1 | Request a readout beat (between trains only) |
| rd_ready_i | input | 1 | Consumer accepts the beat |
| rd_valid_o | output | 1 | Readout beat present |
| rd_ts_o | output | 28 | Cell 0 in bits [13:0], cell 1 in bits [27:14] |
| rd_count_o | output | 2 | Number of stored hits, 0 to 2 |
| rd_empty_o | output | 1 | No hit stored |
| rd_ovf_o | output | 1 | At least one hit was dropped for lack of space |

## Verification
The bench sends a third and fourth hit into a full store. A design that wrapped its pointer would overwrite cell 0, and one without a sticky flag would report no loss. Hits on back-to-back cycles catch a pointer that advances late and writes the same cell twice. Reads held under long back-pressure, and a clear that lands on the same cycle as a read request or during a pending beat, expose beats that change while waiting, duplicate, or survive a clear. Hits, reads and clears issued against the wrong train phase show whether the gating by train_i is missing.

// File: rtl/pix_ts_pkg.sv
package pix_ts_pkg;
  localparam int TS_W_DEF  = 14;
  localparam int NCELL_DEF = 2;

  function automatic int cnt_bits(input int ncell);
    return $clog2(ncell + 1);
  endfunction
endpackage

// File: rtl/pix_ts_store.sv
module pix_ts_store #(
  parameter int TS_W  = pix_ts_pkg::TS_W_DEF,
  parameter int NCELL = pix_ts_pkg::NCELL_DEF,
  localparam int CNT_W = pix_ts_pkg::cnt_bits(NCELL)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cap_en,
  input  logic [TS_W-1:0]         ts,
  input  logic                    wipe,
  output logic [NCELL*TS_W-1:0]   cells,
  output logic [CNT_W-1:0]        count,
  output logic                    ovf
);
  logic full;
  assign full = (count == CNT_W'(NCELL));

  // pointer and sticky loss flag
  always_ff @(posedge clk) begin
    if (!rst_n || wipe) begin
      count <= '0;
      ovf   <= 1'b0;
    end else if (cap_en) begin
      if (full) ovf   <= 1'b1;
      else      count <= count + 1'b1;
    end
  end

  // one register per cell, written when the pointer selects it
  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    logic [TS_W-1:0] slot;
    always_ff @(posedge clk) begin
      if (!rst_n || wipe)
        slot <= '0;
      else if (cap_en && !full && count == CNT_W'(i))
        slot <= ts;
    end
    assign cells[i*TS_W +: TS_W] = slot;
  end
endmodule

// File: rtl/pix_ts_readout.sv
module pix_ts_readout #(
  parameter int TS_W  = pix_ts_pkg::TS_W_DEF,
  parameter int NCELL = pix_ts_pkg::NCELL_DEF,
  localparam int CNT_W = pix_ts_pkg::cnt_bits(NCELL)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_go,
  input  logic                    ready,
  input  logic                    wipe,
  input  logic [NCELL*TS_W-1:0]   cells,
  input  logic [CNT_W-1:0]        count,
  input  logic                    ovf,
  output logic                    valid,
  output logic [NCELL*TS_W-1:0]   ts_q,
  output logic [CNT_W-1:0]        cnt_q,
  output logic                    empty_q,
  output logic                    ovf_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      ts_q    <= '0;
      cnt_q   <= '0;
      empty_q <= 1'b1;
      ovf_q   <= 1'b0;
    end else if (wipe) begin
      valid <= 1'b0;
    end else if (valid) begin
      if (ready) valid <= 1'b0;
    end else if (req_go) begin
      valid   <= 1'b1;
      ts_q    <= cells;
      cnt_q   <= count;
      empty_q <= (count == '0);
      ovf_q   <= ovf;
    end
  end
endmodule

// File: rtl/pix_ts_recorder.sv
module pix_ts_recorder #(
  parameter int TS_W  = pix_ts_pkg::TS_W_DEF,
  parameter int NCELL = pix_ts_pkg::NCELL_DEF,
  localparam int CNT_W = pix_ts_pkg::cnt_bits(NCELL)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    train_i,
  input  logic                    hit_i,
  input  logic [TS_W-1:0]         ts_i,
  input  logic                    clr_i,
  input  logic                    rd_req_i,
  input  logic                    rd_ready_i,
  output logic                    rd_valid_o,
  output logic [NCELL*TS_W-1:0]   rd_ts_o,
  output logic [CNT_W-1:0]        rd_count_o,
  output logic                    rd_empty_o,
  output logic                    rd_ovf_o
);
  logic                  cap_en, wipe, req_go, ovf;
  logic [NCELL*TS_W-1:0] cells;
  logic [CNT_W-1:0]      count;

  assign cap_en = train_i & hit_i;
  assign wipe   = clr_i & ~train_i;
  assign req_go = rd_req_i & ~train_i;

  pix_ts_store #(.TS_W(TS_W), .NCELL(NCELL)) u_store (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .ts(ts_i), .wipe(wipe),
    .cells(cells), .count(count), .ovf(ovf)
  );

  pix_ts_readout #(.TS_W(TS_W), .NCELL(NCELL)) u_rd (
    .clk(clk), .rst_n(rst_n), .req_go(req_go), .ready(rd_ready_i), .wipe(wipe),
    .cells(cells), .count(count), .ovf(ovf),
    .valid(rd_valid_o), .ts_q(rd_ts_o), .cnt_q(rd_count_o),
    .empty_q(rd_empty_o), .ovf_q(rd_ovf_o)
  );
endmodule

// File: rtl/pix_ts_recorder_chk.sv
module pix_ts_recorder_chk #(
  parameter int TS_W  = pix_ts_pkg::TS_W_DEF,
  parameter int NCELL = pix_ts_pkg::NCELL_DEF,
  localparam int CNT_W = pix_ts_pkg::cnt_bits(NCELL)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  train_i,
  input logic                  clr_i,
  input logic                  rd_ready_i,
  input logic                  rd_valid_o,
  input logic [NCELL*TS_W-1:0] rd_ts_o,
  input logic [CNT_W-1:0]      rd_count_o,
  input logic                  rd_empty_o,
  input logic                  rd_ovf_o
);
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o && !rd_ready_i && !(clr_i && !train_i) |=> rd_valid_o && $stable(rd_ts_o)
    && $stable(rd_count_o) && $stable(rd_empty_o) && $stable(rd_ovf_o)); // R9
  AST_BEAT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o && rd_ready_i |=> !rd_valid_o); // R9
  AST_EMPTY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> (rd_empty_o == (rd_count_o == '0))); // R7
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> rd_count_o <= CNT_W'(NCELL)); // R7
  AST_OVF_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o && rd_ovf_o |-> rd_count_o == CNT_W'(NCELL)); // R5
  AST_NO_READ_IN_TRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    train_i && !rd_valid_o |=> !rd_valid_o); // R8
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i && !train_i |=> !rd_valid_o); // R10
endmodule

bind pix_ts_recorder pix_ts_recorder_chk #(.TS_W(TS_W), .NCELL(NCELL)) u_chk (
  .clk(clk), .rst_n(rst_n), .train_i(train_i), .clr_i(clr_i),
  .rd_ready_i(rd_ready_i), .rd_valid_o(rd_valid_o), .rd_ts_o(rd_ts_o),
  .rd_count_o(rd_count_o), .rd_empty_o(rd_empty_o), .rd_ovf_o(rd_ovf_o)
);

// File: tb/pix_ts_recorder_test.sv
module pix_ts_recorder_test;
  logic clk = 0, rst_n = 0;
  logic train = 0, hit = 0, clr = 0, rreq = 0, rrdy = 0;
  logic [13:0] ts = '0;
  logic        v_o, e_o, o_o;
  logic [27:0] t_o;
  logic [1:0]  c_o;

  int    checks = 0, errors = 0;
  string req = "R1";

  // behavioural reference
  int          q[$];
  bit          m_ovf = 0, m_valid = 0, m_empty = 1, m_ovfs = 0;
  int          m_cnt = 0;
  logic [27:0] m_ts = '0;

  always #10 clk = ~clk;

  pix_ts_recorder uut (
    .clk(clk), .rst_n(rst_n), .train_i(train), .hit_i(hit), .ts_i(ts),
    .clr_i(clr), .rd_req_i(rreq), .rd_ready_i(rrdy),
    .rd_valid_o(v_o), .rd_ts_o(t_o), .rd_count_o(c_o),
    .rd_empty_o(e_o), .rd_ovf_o(o_o)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_ovf = 0; m_valid = 0;
    end else if (clr && !train) begin
      q.delete(); m_ovf = 0; m_valid = 0;
    end else begin
      if (m_valid) begin
        if (rrdy) m_valid = 0;
      end else if (rreq && !train) begin
        m_valid = 1; m_cnt = q.size(); m_empty = (q.size() == 0); m_ovfs = m_ovf;
        m_ts = '0;
        foreach (q[k]) m_ts[k*14 +: 14] = q[k][13:0];
      end
      if (train && hit) begin
        if (q.size() < 2) q.push_back(int'(ts));
        else m_ovf = 1;
      end
    end
  end

  task automatic chk(string f, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, f, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
    chk("valid", int'(v_o), int'(m_valid));
    if (m_valid) begin
      chk("ts", int'(t_o), int'(m_ts));
      chk("count", int'(c_o), m_cnt);
      chk("empty", int'(e_o), int'(m_empty));
      chk("ovf", int'(o_o), int'(m_ovfs));
    end
  endtask

  task automatic idle();
    hit = 0; clr = 0; rreq = 0;
  endtask

  task automatic do_hit(logic [13:0] v);
    hit = 1; ts = v; tick(); hit = 0;
  endtask

  task automatic do_read(int hold);
    train = 0; rrdy = 0; rreq = 1; tick(); rreq = 0;
    for (int i = 0; i < hold; i++) tick();
    rrdy = 1; tick(); rrdy = 0;
  endtask

  task automatic do_clr();
    train = 0; clr = 1; tick(); clr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    req = "R1"; tick(); do_read(0);
    req = "R7"; do_read(2);
    req = "R2"; train = 1; do_hit(14'h1A5); tick(); do_read(1);
    req = "R10"; do_clr(); do_read(0);
    req = "R4"; train = 1; hit = 1; ts = 14'h0011; tick(); ts = 14'h3FFE; tick(); hit = 0;
    req = "R3"; do_read(0);
    req = "R9"; do_read(5);
    req = "R9"; train = 0; rreq = 1; tick(); rreq = 1; tick(); rreq = 1; tick(); rreq = 0; rrdy = 1; tick(); rrdy = 0;
    req = "R5"; train = 1; do_hit(14'h0777); do_hit(14'h2222); tick(); do_read(0);
    req = "R6"; do_clr(); train = 0; do_hit(14'h0ABC); do_read(0);
    req = "R8"; train = 1; do_hit(14'h0100); rreq = 1; tick(); tick(); rreq = 0; tick();
    req = "R10"; clr = 1; tick(); clr = 0; train = 0; do_read(0);
    req = "R10"; rreq = 1; tick(); rreq = 0; tick(); clr = 1; tick(); clr = 0; tick();
    req = "R10"; clr = 1; rreq = 1; tick(); idle(); tick(); do_read(0);
    req = "R4";
    for (int n = 0; n < 2000; n++) begin
      train = ($urandom_range(0, 3) != 0) ? ~train : train;
      hit  = $urandom_range(0, 1);
      ts   = 14'($urandom);
      clr  = ($urandom_range(0, 15) == 0);
      rreq = $urandom_range(0, 1);
      rrdy = $urandom_range(0, 1);
      tick();
    end
    idle(); rrdy = 0; train = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule